// File: doc/BRIEF.md
# Dual-Mode 8-Bit PWM Timer

This block is an 8-bit timer that drives one pulse-width-modulated pin. It has two counting schemes. In the wrapping scheme the count climbs from 0x00 to 0xFF and rolls over, so one period lasts 256 timer ticks. In the triangle scheme the count climbs to 0xFF and then descends to 0x00, so one period lasts 510 ticks and the pulse is centred. A prescaler outside the block supplies a one-cycle `tick` qualifier. The counter moves only on cycles where `tick` is high.

Software reaches the block through a small register port with four addresses: threshold, flags, count and control. A threshold written by software waits in a holding register and reads back at once. It becomes active only at a fixed point in the count cycle, so a new duty value never cuts a pulse short. The block keeps two sticky event flags, one for the period boundary and one for a threshold hit. Each flag can raise an interrupt request when its own enable and a global enable are both set. A two-bit pin mode turns the pin off, or selects true or inverted polarity.

Top module: `pwm_timer`

## Requirements
- R1: The count changes only on cycles with `tick` high. In the wrapping scheme (control bit 0 = 0) each tick adds one, modulo 256.
- R2: In the triangle scheme (control bit 0 = 1) the count goes 0x00 up to 0xFF and back down to 0x00. One period is 510 ticks. The period flag is set when the count arrives at 0x00 on the way down, and it is not set at 0xFF.
- R3: In the wrapping scheme the period flag is set on the step from 0xFF to 0x00, once every 256 ticks.
- R4: A write to address 0 loads the holding register. A read of address 0 returns the holding register, so the most recent write reads back before it takes effect.
- R5: The holding value becomes the active threshold only when the count arrives at 0xFF in the triangle scheme, or at 0x00 in the wrapping scheme.
- R6: In the wrapping scheme with pin mode 2'b10, the pin is high while the count is at or below the active threshold, so it stays high for a threshold of 0xFF. Pin mode 2'b11 gives the complement.
- R7: In the triangle scheme with pin mode 2'b10, the pin goes low when the count reaches the threshold while rising, and goes high when it reaches the threshold while falling. This gives 2×threshold high ticks per period. Pin mode 2'b11 gives the complement.
- R8: In the triangle scheme, at the next threshold hit the pin is forced to a fixed level: for pin mode 2'b10, low for threshold 0x00 and high for 0xFF; for pin mode 2'b11, high for 0x00 and low for 0xFF.
- R9: When pin mode bit 1 is 0 (modes 2'b00 and 2'b01), the pin is held low.
- R10: Flags are sticky. Writing 1 to a flag bit at address 1 clears it, and writing 0 leaves it unchanged. A flag event in the same cycle as a clear wins.
- R11: `ovf_irq` is high only while the period flag, control bit 3 and `gie` are all high. `cmp_irq` is high only while the threshold flag, control bit 4 and `gie` are all high.
- R12: Address map: 0 threshold, 1 flags (bit 0 period, bit 1 threshold), 2 count (read-only; writes are ignored), 3 control (bit 0 scheme, bits 2:1 pin mode, bit 3 period IE, bit 4 threshold IE). All state resets to zero.
- R13: The threshold flag is set when a tick brings the count to a value equal to the active threshold, in both schemes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| gie | input | 1 | Global interrupt enable |
| pwm_out | output | 1 | Modulated pin |
| ovf_flag | output | 1 | Sticky period flag |
| cmp_flag | output | 1 | Sticky threshold flag |
| ovf_irq | output | 1 | Period interrupt request |
| cmp_irq | output | 1 | Threshold interrupt request |

## Verification
The properties assume that reset is asserted before the first tick and that `tick` is a plain level sampled each clock, with no timing tie to register writes. The step-size property for the triangle scheme also assumes that a scheme change from wrapping to triangle can happen at any count. The counter guard at 0xFF keeps that step at one, and the stimulus switches schemes freely between table rows to exercise this. Register writes in the directed part are issued only while `tick` is low, so every count value the bench waits for is seen exactly once.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    PIN_OFF_A  = 2'b00,
    PIN_OFF_B  = 2'b01,
    PIN_TRUE   = 2'b10,
    PIN_INVERT = 2'b11
  } pin_mode_e;

  localparam int REG_THR   = 0;
  localparam int REG_FLAGS = 1;
  localparam int REG_COUNT = 2;
  localparam int REG_CTRL  = 3;

  localparam int CTL_SCHEME = 0;
  localparam int CTL_PIN_LO = 1;
  localparam int CTL_OVF_IE = 3;
  localparam int CTL_CMP_IE = 4;
  localparam int CTL_BITS   = 5;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         triangle,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         rising
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic dir_q, dir_nxt;

  // returns {direction of the following move, next count}
  function automatic logic [W:0] advance(input logic [W-1:0] c, input logic up,
                                         input logic tri_m);
    logic [W-1:0] n;
    logic         d;
    if (!tri_m) begin
      n = c + 1'b1;
      d = 1'b1;
    end else if (up && c != TOP) begin
      n = c + 1'b1;
      d = (n != TOP);
    end else if (up) begin
      n = TOP - 1'b1;
      d = 1'b0;
    end else begin
      n = c - 1'b1;
      d = (n == '0);
    end
    return {d, n};
  endfunction

  always_comb begin
    if (tick) {dir_nxt, cnt_nxt} = advance(cnt_q, dir_q, triangle);
    else      {dir_nxt, cnt_nxt} = {dir_q, cnt_q};
  end

  assign rising = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      dir_q <= dir_nxt;
    end
  end
endmodule

// File: rtl/pwm_thr_buf.sv
module pwm_thr_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_we,
  input  logic [W-1:0] hold_d,
  input  logic         load,
  output logic [W-1:0] hold_q,
  output logic [W-1:0] act_q,
  output logic [W-1:0] act_nxt
);
  assign act_nxt = load ? hold_q : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (hold_we) hold_q <= hold_d;
      act_q <= act_nxt;
    end
  end
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         triangle,
  input  logic         invert,
  input  logic         hit,
  input  logic         rising,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] thr_nxt,
  output logic         level_q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic wrap_level(input logic [W-1:0] c, input logic [W-1:0] t,
                                      input logic inv);
    return (c <= t) ^ inv;
  endfunction

  function automatic logic tri_level(input logic [W-1:0] t, input logic up,
                                     input logic inv);
    if (t == '0)  return inv;
    if (t == TOP) return !inv;
    return (!up) ^ inv;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                level_q <= 1'b0;
    else if (tick && !triangle) level_q <= wrap_level(cnt_nxt, thr_nxt, invert);
    else if (hit && triangle)   level_q <= tri_level(thr_nxt, rising, invert);
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic              gie,
  output logic              pwm_out,
  output logic              ovf_flag,
  output logic              cmp_flag,
  output logic              ovf_irq,
  output logic              cmp_irq
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [CTL_BITS-1:0] ctrl_q;
  logic [W-1:0]        cnt_q, cnt_nxt, hold_q, act_q, act_nxt;
  logic                rising, level_q;
  logic                triangle, ovf_ie, cmp_ie;
  pin_mode_e           pin_mode;
  logic                ovf_evt, top_evt, load_evt, cmp_evt;
  logic                wr_thr, wr_flags, wr_ctrl;

  assign triangle = ctrl_q[CTL_SCHEME];
  assign pin_mode = pin_mode_e'(ctrl_q[CTL_PIN_LO +: 2]);
  assign ovf_ie   = ctrl_q[CTL_OVF_IE];
  assign cmp_ie   = ctrl_q[CTL_CMP_IE];

  assign wr_thr   = wr_en && (wr_addr == ADDR_W'(REG_THR));
  assign wr_flags = wr_en && (wr_addr == ADDR_W'(REG_FLAGS));
  assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(REG_CTRL));

  // named events for the checker
  assign ovf_evt  = tick && (cnt_nxt == '0);
  assign top_evt  = tick && (cnt_nxt == TOP);
  assign load_evt = triangle ? top_evt : ovf_evt;
  assign cmp_evt  = tick && (cnt_nxt == act_nxt);

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .triangle(triangle),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .rising(rising)
  );

  pwm_thr_buf #(.W(W)) u_thr (
    .clk(clk), .rst_n(rst_n), .hold_we(wr_thr), .hold_d(wr_data),
    .load(load_evt), .hold_q(hold_q), .act_q(act_q), .act_nxt(act_nxt)
  );

  pwm_wave #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .triangle(triangle),
    .invert(pin_mode == PIN_INVERT), .hit(cmp_evt), .rising(rising),
    .cnt_nxt(cnt_nxt), .thr_nxt(act_nxt), .level_q(level_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[CTL_BITS-1:0];
      ovf_flag <= ovf_evt || (ovf_flag && !(wr_flags && wr_data[0]));
      cmp_flag <= cmp_evt || (cmp_flag && !(wr_flags && wr_data[1]));
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_W'(REG_THR):   rd_data = hold_q;
      ADDR_W'(REG_FLAGS): rd_data = W'({cmp_flag, ovf_flag});
      ADDR_W'(REG_COUNT): rd_data = cnt_q;
      default:            rd_data = W'(ctrl_q);
    endcase
  end

  assign pwm_out = (pin_mode == PIN_TRUE || pin_mode == PIN_INVERT) ? level_q : 1'b0;
  assign ovf_irq = ovf_flag && ovf_ie && gie;
  assign cmp_irq = cmp_flag && cmp_ie && gie;
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         triangle,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] act_q,
  input logic         ovf_evt,
  input logic         cmp_evt,
  input logic         ovf_flag,
  input logic         cmp_flag,
  input logic         gie,
  input logic         ovf_irq,
  input logic         cmp_irq
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R1
  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !triangle) |=> (cnt_q == W'($past(cnt_q) + 1'b1))); // R1
  AST_TRI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && triangle) |=> ((cnt_q == W'($past(cnt_q) + 1'b1)) ||
                            (cnt_q == W'($past(cnt_q) - 1'b1)))); // R2
  AST_LATCH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> (cnt_q == '0 || cnt_q == TOP)); // R5
  AST_OVF_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag); // R10
  AST_CMP_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cmp_flag); // R13
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (!ovf_irq && !cmp_irq)); // R11
endmodule

bind pwm_timer pwm_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .triangle(triangle),
  .cnt_q(cnt_q), .act_q(act_q), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt),
  .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .gie(gie),
  .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
);

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       gie = 1'b0;
  logic       pwm_out, ovf_flag, cmp_flag, ovf_irq, cmp_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .gie(gie),
    .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
    .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
  );

  // ctrl: bit0 triangle, bits2:1 pin mode, period length, expected high ticks
  typedef struct packed {
    logic [7:0] ctrl;
    logic [7:0] thr;
    logic [9:0] period;
    logic [9:0] high;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{8'h04, 8'h40, 10'd256, 10'd65},   // R6 wrap true
    '{8'h04, 8'hFF, 10'd256, 10'd256},  // R6 wrap true, held high
    '{8'h04, 8'h00, 10'd256, 10'd1},    // R6 wrap true, zero threshold
    '{8'h06, 8'h40, 10'd256, 10'd191},  // R6 wrap inverted
    '{8'h06, 8'hFF, 10'd256, 10'd0},    // R6 wrap inverted, held low
    '{8'h05, 8'h40, 10'd510, 10'd128},  // R7 triangle true
    '{8'h05, 8'h00, 10'd510, 10'd0},    // R8 forced low
    '{8'h05, 8'hFF, 10'd510, 10'd510},  // R8 forced high
    '{8'h07, 8'h00, 10'd510, 10'd510},  // R8 inverted forced high
    '{8'h07, 8'hFF, 10'd510, 10'd0},    // R8 inverted forced low
    '{8'h07, 8'h30, 10'd510, 10'd414},  // R7 triangle inverted
    '{8'h01, 8'h40, 10'd510, 10'd0}     // R9 pin off
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic step();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic step_until(input int target);
    int v;
    for (int i = 0; i < 1100; i++) begin
      rd(2, v);
      if (v == target) return;
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, hi, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(2, v); chk("R12 count reset", v, 0);
    rd(0, v); chk("R12 threshold reset", v, 0);
    rd(3, v); chk("R12 control reset", v, 0);
    rd(1, v); chk("R12 flags reset", v, 0);
    chk("R12 pin reset", pwm_out, 0);

    // R1 no tick, no motion
    repeat (20) @(negedge clk);
    rd(2, v); chk("R1 frozen without tick", v, 0);
    repeat (5) step();
    rd(2, v); chk("R1 five ticks", v, 5);
    wr(2, 8'h77);
    rd(2, v); chk("R12 count write ignored", v, 5);

    // table of duty vectors
    foreach (VEC[k]) begin
      wr(3, VEC[k].ctrl);
      wr(0, VEC[k].thr);
      tick = 1'b1;
      repeat (1100) @(negedge clk);
      hi = 0;
      for (int j = 0; j < int'(VEC[k].period); j++) begin
        @(negedge clk);
        hi += int'(pwm_out);
      end
      tick = 1'b0;
      chk($sformatf("R6/R7/R8/R9 vector %0d high ticks", k), hi, int'(VEC[k].high));
    end

    // R3, R10 wrap period flag
    wr(3, 8'h04);
    step_until(8'h10);
    wr(1, 8'h03);
    step_until(8'hFF);
    chk("R3 no flag before wrap", ovf_flag, 0);
    step();
    rd(2, v); chk("R3 wrap to zero", v, 0);
    chk("R3 flag on wrap", ovf_flag, 1);
    wr(1, 8'h00);
    chk("R10 zero write keeps flag", ovf_flag, 1);

    // R11 interrupt gating
    wr(3, 8'h0C);
    chk("R11 no irq without gie", ovf_irq, 0);
    @(negedge clk); gie = 1'b1; #1;
    chk("R11 irq with gie and enable", ovf_irq, 1);
    wr(3, 8'h04);
    chk("R11 no irq without enable", ovf_irq, 0);

    wr(1, 8'h01);
    chk("R10 one write clears flag", ovf_flag, 0);
    n = 0;
    while (!ovf_flag && n < 600) begin step(); n++; end
    chk("R3 wrap period", n, 256);

    // R13 threshold flag
    wr(0, 8'h40);
    step();
    step_until(8'h00);
    wr(1, 8'h03);
    step_until(8'h3F);
    chk("R13 no hit below threshold", cmp_flag, 0);
    step();
    chk("R13 hit at threshold", cmp_flag, 1);

    // R4, R5 wrap latch point (active 0x40)
    step_until(8'h18);
    wr(0, 8'h08);
    rd(0, v); chk("R4 holding reads back", v, 8'h08);
    step_until(8'h20);
    chk("R5 old threshold still active", pwm_out, 1);
    step_until(8'h00);
    step_until(8'h20);
    chk("R5 new threshold after wrap", pwm_out, 0);

    // R2 triangle period flag
    wr(3, 8'h05);
    step_until(8'h00);
    step_until(8'h10);
    wr(1, 8'h03);
    step_until(8'hFF);
    chk("R2 no flag at top", ovf_flag, 0);
    step();
    rd(2, v); chk("R2 turns down at top", v, 8'hFE);
    step_until(8'h01);
    chk("R2 no flag before bottom", ovf_flag, 0);
    step();
    rd(2, v); chk("R2 reaches bottom", v, 0);
    chk("R2 flag at bottom", ovf_flag, 1);
    wr(1, 8'h01);
    n = 0;
    while (!ovf_flag && n < 1100) begin step(); n++; end
    chk("R2 triangle period", n, 510);

    // R5, R7 triangle latch point
    wr(0, 8'h80);
    step_until(8'hFF);
    step_until(8'h10);
    chk("R7 high after falling hit", pwm_out, 1);
    wr(0, 8'h20);
    step_until(8'h00);
    step_until(8'h50);
    chk("R5 old threshold kept while rising", pwm_out, 1);
    step_until(8'hFF);
    step_until(8'h50);
    chk("R5 new threshold after top", pwm_out, 0);
    step_until(8'h20);
    chk("R7 set on falling hit", pwm_out, 1);
    step_until(8'h00);
    step_until(8'h21);
    chk("R7 cleared on rising hit", pwm_out, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule